// File: doc/BRIEF.md
# Job Ring Occupancy and Interrupt Tracker

This block keeps the books for one pair of job rings shared between software and a processing engine: an input ring that software fills with job entries and an output ring that the engine fills with completion records. Software does not push or pop single entries. It writes a count of jobs it has just placed in the input ring and a count of completion records it has just taken out of the output ring. The engine reports, one strobe at a time, that it has taken a job from the input ring or written a completion into the output ring.

From these events the block keeps the free space left in the input ring, the number of occupied output slots, the index of the next input entry the engine will read and the index of the next output entry the engine will write. Both indices wrap at the programmed ring sizes. Completions raise an interrupt, either one per completion or coalesced by a count threshold and a timeout. Count writes that would overflow a ring are rejected and reported with an encoded error type and the offending count. A ring reset command halts the ring, clears all counts and indices and then reports that the halt is complete.

Top module: `jring_track`

## Requirements
- R1: After reset, in_room_o equals in_size_i, out_full_o, in_rd_idx_o and out_wr_idx_o are 0, int_status_o is 0 and irq_o is 0.
- R2: A jobs-added write of N lowers in_room_o by N one cycle later. An accepted job_take_i strobe, taken only while the input ring holds at least one job, raises in_room_o by 1 and advances in_rd_idx_o by 1.
- R3: A jobs-removed write of N lowers out_full_o by N one cycle later. An accepted job_done_i strobe, taken only while the output ring is not full, raises out_full_o by 1 and advances out_wr_idx_o by 1.
- R4: Each index returns to 0 when it would step to the size of its ring.
- R5: A jobs-added write with N greater than in_room_o leaves all counters unchanged. It sets int_status_o bit 1, puts error type 9 in bits 11:8 and puts N in bits 29:16. While bit 1 is set, the first error's type and count are kept.
- R6: A jobs-removed write with N greater than out_full_o leaves all counters unchanged. It sets bit 1 and reports error type 8 with N in bits 29:16.
- R7: With coalescing off, every accepted completion sets int_status_o bit 0. irq_o is high whenever bit 0 or bit 1 is set and the mask is clear.
- R8: While int_mask_i is high, irq_o is 0. The status bits still set as usual.
- R9: With coal_en_i high, bit 0 is set on the accepted completion that makes the number of completions since the last interrupt reach cnt_thr_i.
- R10: With coal_en_i high and tmr_thr_i nonzero, bit 0 is set tmr_thr_i cycles after the first pending completion, unless the count threshold fires first.
- R11: While stop_err_i is high and bit 1 is set, job_take_i and job_done_i are ignored.
- R12: ring_reset_i sets halt status bits 3:2 to 1 for one cycle. Counts and indices are then 0 and bits 3:2 read 2. A count write during that cycle is dropped and reported as error type 7 with its N.
- R13: Writing int_clr_i bit 0 clears status bit 0. Writing bit 1 clears bit 1, the error type, the error count and a completed halt indication. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_size_i | input | 10 | Input ring size in entries |
| out_size_i | input | 10 | Output ring size in entries |
| int_mask_i | input | 1 | Interrupt mask (config bit 0) |
| coal_en_i | input | 1 | Coalescing enable (config bit 1) |
| stop_err_i | input | 1 | Halt engine strobes on error (config bit 2) |
| cnt_thr_i | input | 8 | Completion count threshold (config bits 15:8) |
| tmr_thr_i | input | 16 | Coalescing timeout in cycles, 0 disables (config bits 31:16) |
| jobs_add_we_i | input | 1 | Jobs-added count write strobe |
| jobs_add_i | input | 10 | Number of jobs added |
| jobs_rmv_we_i | input | 1 | Jobs-removed count write strobe |
| jobs_rmv_i | input | 10 | Number of completions removed |
| job_take_i | input | 1 | Engine took one job from the input ring |
| job_done_i | input | 1 | Engine wrote one completion to the output ring |
| ring_reset_i | input | 1 | Command write with the ring-reset bit set |
| int_clr_we_i | input | 1 | Status write-one-to-clear strobe |
| int_clr_i | input | 2 | Bits to clear: 0 interrupt, 1 error and halt |
| in_room_o | output | 10 | Free entries in the input ring |
| out_full_o | output | 10 | Occupied entries in the output ring |
| in_rd_idx_o | output | 10 | Next input entry the engine reads |
| out_wr_idx_o | output | 10 | Next output entry the engine writes |
| int_status_o | output | 32 | Interrupt, error and halt status |
| irq_o | output | 1 | Interrupt request |

## Verification
Each count write, engine strobe, clear and reset command takes effect at the first clock edge that samples it, so its effect on the counters, indices and status is read one cycle later. irq_o follows status and the mask with no register in between, so a mask change is seen without waiting for an edge. The timeout path needs tmr_thr_i edges after the edge that recorded the first pending completion. The bench steps edge by edge and checks that the flag is still clear before that edge and set just after it. Inputs are driven one nanosecond after an edge and outputs are read one nanosecond after the next edge, so every check lands in the cycle its result is due.

// File: rtl/jring_pkg.sv
package jring_pkg;
  localparam int EIW = 14;

  typedef enum logic [3:0] {
    ET_NONE    = 4'd0,
    ET_RESET   = 4'd7,
    ET_RMV_OVF = 4'd8,
    ET_ADD_OVF = 4'd9
  } err_type_e;

  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_BUSY = 2'd1,
    H_DONE = 2'd2
  } halt_e;
endpackage

// File: rtl/jring_side.sv
module jring_side #(
  parameter int CW       = 10,
  parameter bit SW_FILLS = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] size_i,
  input  logic          sw_we_i,
  input  logic [CW-1:0] sw_cnt_i,
  input  logic          hw_step_i,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] idx_o,
  output logic          ovf_o,
  output logic          hw_ok_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] occ_q, idx_q, room, sw_amt, hw_amt, idx_inc;

  assign room = size_i - occ_q;

  generate
    if (SW_FILLS) begin : g_fill
      assign ovf_o   = sw_we_i && (sw_cnt_i > room);
      assign hw_ok_o = hw_step_i && (occ_q != '0);
    end else begin : g_drain
      assign ovf_o   = sw_we_i && (sw_cnt_i > occ_q);
      assign hw_ok_o = hw_step_i && (occ_q != size_i);
    end
  endgenerate

  assign sw_amt  = (sw_we_i && !ovf_o) ? sw_cnt_i : '0;
  assign hw_amt  = hw_ok_o ? ONE : '0;
  assign idx_inc = idx_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      occ_q <= '0;
      idx_q <= '0;
    end else begin
      occ_q <= SW_FILLS ? (occ_q + sw_amt - hw_amt) : (occ_q + hw_amt - sw_amt);
      if (hw_ok_o) idx_q <= (idx_inc == size_i) ? '0 : idx_inc;
    end
  end

  assign occ_o = occ_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/jring_coal.sv
module jring_coal #(
  parameter int CTW = 8,
  parameter int TTW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic           coal_en_i,
  input  logic [CTW-1:0] cnt_thr_i,
  input  logic [TTW-1:0] tmr_thr_i,
  output logic           fire_o
);
  logic [CTW-1:0] pend_q;
  logic [TTW-1:0] tmr_q;
  logic           cnt_hit, tmr_hit;

  assign cnt_hit = step_i && (({1'b0, pend_q} + (CTW+1)'(1)) >= {1'b0, cnt_thr_i});
  assign tmr_hit = (tmr_thr_i != '0) && (pend_q != '0) &&
                   (({1'b0, tmr_q} + (TTW+1)'(1)) >= {1'b0, tmr_thr_i});
  assign fire_o  = coal_en_i ? (cnt_hit || tmr_hit) : step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      tmr_q  <= '0;
    end else if (clr_i || fire_o || !coal_en_i) begin
      pend_q <= '0;
      tmr_q  <= '0;
    end else begin
      if (step_i && (pend_q != '1)) pend_q <= pend_q + CTW'(1);
      if ((pend_q != '0) && (tmr_q != '1)) tmr_q <= tmr_q + TTW'(1);
    end
  end
endmodule

// File: rtl/jring_track.sv
module jring_track
  import jring_pkg::*;
#(
  parameter int CW  = 10,
  parameter int CTW = 8,
  parameter int TTW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  in_size_i,
  input  logic [CW-1:0]  out_size_i,
  input  logic           int_mask_i,
  input  logic           coal_en_i,
  input  logic           stop_err_i,
  input  logic [CTW-1:0] cnt_thr_i,
  input  logic [TTW-1:0] tmr_thr_i,
  input  logic           jobs_add_we_i,
  input  logic [CW-1:0]  jobs_add_i,
  input  logic           jobs_rmv_we_i,
  input  logic [CW-1:0]  jobs_rmv_i,
  input  logic           job_take_i,
  input  logic           job_done_i,
  input  logic           ring_reset_i,
  input  logic           int_clr_we_i,
  input  logic [1:0]     int_clr_i,
  output logic [CW-1:0]  in_room_o,
  output logic [CW-1:0]  out_full_o,
  output logic [CW-1:0]  in_rd_idx_o,
  output logic [CW-1:0]  out_wr_idx_o,
  output logic [31:0]    int_status_o,
  output logic           irq_o
);
  logic           int_q, err_q;
  err_type_e      etype_q, etype_d;
  logic [EIW-1:0] eidx_q, eidx_d;
  halt_e          halt_q;

  logic busy, hw_en, err_set, fire;
  logic add_ovf, rmv_ovf, take_ok, done_ok;
  logic [CW-1:0] in_occ;

  assign busy  = (halt_q == H_BUSY);
  assign hw_en = !busy && !(err_q && stop_err_i);

  jring_side #(.CW(CW), .SW_FILLS(1'b1)) u_in (
    .clk_i, .rst_ni, .clr_i(busy), .size_i(in_size_i),
    .sw_we_i(jobs_add_we_i && !busy), .sw_cnt_i(jobs_add_i),
    .hw_step_i(job_take_i && hw_en),
    .occ_o(in_occ), .idx_o(in_rd_idx_o), .ovf_o(add_ovf), .hw_ok_o(take_ok)
  );

  jring_side #(.CW(CW), .SW_FILLS(1'b0)) u_out (
    .clk_i, .rst_ni, .clr_i(busy), .size_i(out_size_i),
    .sw_we_i(jobs_rmv_we_i && !busy), .sw_cnt_i(jobs_rmv_i),
    .hw_step_i(job_done_i && hw_en),
    .occ_o(out_full_o), .idx_o(out_wr_idx_o), .ovf_o(rmv_ovf), .hw_ok_o(done_ok)
  );

  jring_coal #(.CTW(CTW), .TTW(TTW)) u_coal (
    .clk_i, .rst_ni, .clr_i(busy), .step_i(done_ok), .coal_en_i,
    .cnt_thr_i, .tmr_thr_i, .fire_o(fire)
  );

  // first matching cause wins; write during halt outranks overflow
  always_comb begin
    err_set = 1'b1;
    etype_d = ET_NONE;
    eidx_d  = '0;
    if (busy && jobs_add_we_i) begin
      etype_d = ET_RESET;   eidx_d = EIW'(jobs_add_i);
    end else if (busy && jobs_rmv_we_i) begin
      etype_d = ET_RESET;   eidx_d = EIW'(jobs_rmv_i);
    end else if (add_ovf) begin
      etype_d = ET_ADD_OVF; eidx_d = EIW'(jobs_add_i);
    end else if (rmv_ovf) begin
      etype_d = ET_RMV_OVF; eidx_d = EIW'(jobs_rmv_i);
    end else begin
      err_set = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q   <= 1'b0;
      err_q   <= 1'b0;
      etype_q <= ET_NONE;
      eidx_q  <= '0;
      halt_q  <= H_IDLE;
    end else begin
      if (int_clr_we_i && int_clr_i[0]) int_q <= 1'b0;
      if (fire) int_q <= 1'b1;
      if (int_clr_we_i && int_clr_i[1]) begin
        err_q   <= 1'b0;
        etype_q <= ET_NONE;
        eidx_q  <= '0;
        if (halt_q == H_DONE) halt_q <= H_IDLE;
      end
      if (err_set && !err_q) begin
        err_q   <= 1'b1;
        etype_q <= etype_d;
        eidx_q  <= eidx_d;
      end
      if (busy) halt_q <= H_DONE;
      else if (ring_reset_i) halt_q <= H_BUSY;
    end
  end

  assign in_room_o    = in_size_i - in_occ;
  assign int_status_o = {2'b00, eidx_q, 4'b0000, etype_q, 4'b0000, halt_q, err_q, int_q};
  assign irq_o        = (int_q || err_q) && !int_mask_i;
endmodule

// File: rtl/jring_track_chk.sv
module jring_track_chk #(
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] in_size_i,
  input logic [CW-1:0] out_size_i,
  input logic          int_mask_i,
  input logic          stop_err_i,
  input logic          jobs_add_we_i,
  input logic [CW-1:0] jobs_add_i,
  input logic [CW-1:0] in_room_o,
  input logic [CW-1:0] out_full_o,
  input logic [CW-1:0] in_rd_idx_o,
  input logic [CW-1:0] out_wr_idx_o,
  input logic [31:0]   int_status_o,
  input logic          irq_o
);
  p_room_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_room_o <= in_size_i);

  p_full_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_full_o <= out_size_i);

  p_idx_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_size_i != '0 && out_size_i != '0) |->
      (in_rd_idx_o < in_size_i && out_wr_idx_o < out_size_i));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jobs_add_we_i && jobs_add_i > in_room_o && int_status_o[3:2] != 2'd1)
      |=> int_status_o[1]);

  p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_mask_i |-> !irq_o);

  p_stop_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_err_i && int_status_o[1] && int_status_o[3:2] != 2'd1)
      |=> ($stable(in_rd_idx_o) && $stable(out_wr_idx_o)));

  p_halt_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_status_o[3:2] == 2'd1) |=>
      (int_status_o[3:2] == 2'd2 && in_rd_idx_o == '0 &&
       out_wr_idx_o == '0 && out_full_o == '0));
endmodule

bind jring_track jring_track_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .in_size_i, .out_size_i, .int_mask_i, .stop_err_i,
  .jobs_add_we_i, .jobs_add_i, .in_room_o, .out_full_o, .in_rd_idx_o,
  .out_wr_idx_o, .int_status_o, .irq_o
);

// File: tb/sim_jring_track.sv
module sim_jring_track;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [9:0]  in_size = 10'd5, out_size = 10'd6;
  logic        mask = 0, coal = 0, soe = 0;
  logic [7:0]  cthr = 0;
  logic [15:0] tthr = 0;
  logic        add_we = 0, rmv_we = 0, take = 0, done = 0, rreset = 0, clr_we = 0;
  logic [9:0]  add_n = 0, rmv_n = 0;
  logic [1:0]  clr_b = 0;
  logic [9:0]  room, full, rd_idx, wr_idx;
  logic [31:0] stat;
  logic        irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  jring_track u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_size_i(in_size), .out_size_i(out_size),
    .int_mask_i(mask), .coal_en_i(coal), .stop_err_i(soe), .cnt_thr_i(cthr),
    .tmr_thr_i(tthr), .jobs_add_we_i(add_we), .jobs_add_i(add_n),
    .jobs_rmv_we_i(rmv_we), .jobs_rmv_i(rmv_n), .job_take_i(take),
    .job_done_i(done), .ring_reset_i(rreset), .int_clr_we_i(clr_we),
    .int_clr_i(clr_b), .in_room_o(room), .out_full_o(full),
    .in_rd_idx_o(rd_idx), .out_wr_idx_o(wr_idx), .int_status_o(stat), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_add(input int n);
    add_we = 1; add_n = 10'(n); step(); add_we = 0;
  endtask
  task automatic do_rmv(input int n);
    rmv_we = 1; rmv_n = 10'(n); step(); rmv_we = 0;
  endtask
  task automatic do_take();
    take = 1; step(); take = 0;
  endtask
  task automatic do_done();
    done = 1; step(); done = 0;
  endtask
  task automatic do_clr(input logic [1:0] b);
    clr_we = 1; clr_b = b; step(); clr_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 room", 32'(room), 32'd5);
    chk("R1 full", 32'(full), 0);
    chk("R1 rd", 32'(rd_idx), 0);
    chk("R1 wr", 32'(wr_idx), 0);
    chk("R1 status", stat, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_add_take();
    do_add(3);
    chk("R2 room after add", 32'(room), 32'd2);
    do_take();
    chk("R2 room after take", 32'(room), 32'd3);
    chk("R2 rd idx", 32'(rd_idx), 32'd1);
  endtask

  task automatic t_done_rmv();
    do_done();
    chk("R3 full after done", 32'(full), 32'd1);
    chk("R3 wr idx", 32'(wr_idx), 32'd1);
    chk("R7 status bit0", stat, 32'h1);
    chk("R7 irq", 32'(irq), 1);
    do_clr(2'b01);
    chk("R13 clear bit0", stat, 0);
    chk("R13 irq low", 32'(irq), 0);
    do_done();
    do_rmv(2);
    chk("R3 full after remove", 32'(full), 0);
    do_clr(2'b01);
  endtask

  task automatic t_wrap();
    do_add(3);
    chk("R2 room full ring", 32'(room), 0);
    for (int i = 0; i < 4; i++) do_take();
    chk("R4 rd idx wraps", 32'(rd_idx), 0);
    chk("R2 room after takes", 32'(room), 32'd4);
    for (int i = 0; i < 4; i++) do_done();
    chk("R4 wr idx wraps", 32'(wr_idx), 0);
    chk("R3 full after dones", 32'(full), 32'd4);
    do_rmv(4);
    do_clr(2'b01);
  endtask

  task automatic t_ovf();
    do_add(5);
    chk("R5 add ovf status", stat, 32'h0005_0902);
    chk("R5 room unchanged", 32'(room), 32'd4);
    chk("R7 irq on error", 32'(irq), 1);
    do_rmv(3);
    chk("R5 first error kept", stat, 32'h0005_0902);
    do_clr(2'b10);
    chk("R13 clear error", stat, 0);
    do_rmv(3);
    chk("R6 rmv ovf status", stat, 32'h0003_0802);
    chk("R6 full unchanged", 32'(full), 0);
    do_clr(2'b10);
  endtask

  task automatic t_mask();
    mask = 1;
    do_done();
    chk("R8 status still set", stat, 32'h1);
    chk("R8 irq masked", 32'(irq), 0);
    mask = 0; #1;
    chk("R7 irq after unmask", 32'(irq), 1);
    do_clr(2'b01);
    do_rmv(1);
  endtask

  task automatic t_soe();
    soe = 1;
    do_add(10);
    chk("R5 error flagged", stat[1:0], 32'h2);
    do_take();
    chk("R11 take ignored rd", 32'(rd_idx), 0);
    chk("R11 take ignored room", 32'(room), 32'd4);
    do_done();
    chk("R11 done ignored", 32'(full), 0);
    chk("R11 no interrupt", 32'(stat[0]), 0);
    do_clr(2'b10);
    do_take();
    chk("R11 take after clear", 32'(rd_idx), 32'd1);
    soe = 0;
  endtask

  task automatic t_coal_cnt();
    coal = 1; cthr = 8'd3; tthr = 0;
    do_done(); do_done();
    chk("R9 below threshold", 32'(stat[0]), 0);
    do_done();
    chk("R9 at threshold", 32'(stat[0]), 1);
    do_clr(2'b01);
    do_rmv(3);
  endtask

  task automatic t_coal_tmr();
    coal = 1; cthr = 8'd100; tthr = 16'd4;
    do_done();
    chk("R10 not at once", 32'(stat[0]), 0);
    step(); step();
    step();
    chk("R10 before timeout", 32'(stat[0]), 0);
    step();
    chk("R10 at timeout", 32'(stat[0]), 1);
    do_clr(2'b01);
    do_rmv(1);
    coal = 0; cthr = 0; tthr = 0;
  endtask

  task automatic t_ring_reset();
    do_add(2);
    chk("R2 room before reset", 32'(room), 32'd3);
    rreset = 1; step(); rreset = 0;
    chk("R12 halt in progress", stat, 32'h4);
    do_add(1);
    chk("R12 halt done and error", stat, 32'h0001_070A);
    chk("R12 room cleared", 32'(room), 32'd5);
    chk("R12 rd cleared", 32'(rd_idx), 0);
    chk("R12 wr cleared", 32'(wr_idx), 0);
    chk("R12 full cleared", 32'(full), 0);
    do_clr(2'b10);
    chk("R13 halt cleared", stat, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_add_take();
    t_done_rmv();
    t_wrap();
    t_ovf();
    t_mask();
    t_soe();
    t_coal_cnt();
    t_coal_tmr();
    t_ring_reset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule